// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

Each cycle this block looks at the pending synchronous exception, the pending external interrupt and the processor's current status. It decides whether to enter a handler, to raise a reset request, or to do nothing. On entry it captures the interrupted context in shadow registers and builds the new status word. It also produces the handler address, which is the vector base plus a per-class offset, or a fixed reset address for reset-class codes.

The surrounding core presents the event and its context for one cycle. At the next clock edge it loads its program counter and status register from `new_pc` and `new_sr` when `taken` pulses. `wake` tells the core to leave sleep and `dslot_clr` tells it to drop its delay-slot flag. The current interrupt mask level goes out on `irq_lvl`, so the external interrupt controller can decide whether its vector is valid.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending exception takes precedence over a pending interrupt. The interrupt is considered only when no exception is pending, and then `intevt` keeps its value.
- R2: When status bit 28 (block) is set and an exception with a code other than 0x1E0 is pending, `rst_req` pulses for one cycle. No handler is entered and all saved state is left unchanged.
- R3: Exception code 0x1E0 is entered normally even while status bit 28 is set.
- R4: While status bit 28 is set, an interrupt is ignored unless `sleep_in` is high. Every entry pulses `wake`.
- R5: An interrupt is entered only when `irq_vec_ok` is high. `irq_lvl` always shows status bits 7:4.
- R6: On entry, `ssr` takes the status input and `sgr` takes `r15_in`. `new_sr` is the status input with bits 30, 29 and 28 set.
- R7: If `dslot_in` is high on entry, `spc` is `pc_in` minus 2 and `dslot_clr` pulses. Otherwise `spc` is `pc_in`.
- R8: Codes 0x000, 0x020 and 0x140 also clear status bit 15, set status bits 7:4 to 0xF and load `new_pc` with 0xA0000000.
- R9: Codes 0x040 and 0x060 go to `vbr_in` + 0x400. Any other non-reset exception goes to `vbr_in` + 0x100.
- R10: Code 0x160 adds 2 to the saved `spc`, applied after any delay-slot correction.
- R11: An exception writes its code to `expevt`. An interrupt writes its vector to `intevt`, goes to `vbr_in` + 0x600 and leaves `expevt` unchanged.
- R12: All updates of one entry commit at one clock edge, together with a one-cycle `taken` pulse. With nothing taken, all saved state holds. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_pend | input | 1 | A synchronous exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | External interrupt request |
| irq_vec_ok | input | 1 | Controller holds a vector valid for `irq_lvl` |
| irq_vec | input | 12 | Interrupt vector from the controller |
| irq_lvl | output | 4 | Current interrupt mask level (status bits 7:4) |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Program counter of the interrupted instruction |
| r15_in | input | 32 | Current stack pointer register |
| vbr_in | input | 32 | Vector base |
| dslot_in | input | 1 | Interrupted instruction sits in a delay slot |
| sleep_in | input | 1 | Core is sleeping |
| taken | output | 1 | One-cycle pulse: a handler was entered |
| rst_req | output | 1 | One-cycle pulse: blocked exception, reset required |
| wake | output | 1 | One-cycle pulse: clear the sleep state |
| dslot_clr | output | 1 | One-cycle pulse: clear the delay-slot flag |
| new_pc | output | 32 | Handler address of the last entry |
| new_sr | output | 32 | Status word of the last entry |
| ssr | output | 32 | Saved status |
| spc | output | 32 | Saved program counter |
| sgr | output | 32 | Saved stack pointer |
| expevt | output | 12 | Last exception code entered |
| intevt | output | 12 | Last interrupt vector entered |

## Verification
The stimulus covers each code class in turn: general, both TLB-miss codes, the trap with and without a delay slot, and all three reset-class codes. Each one must land on its own target address and its own saved-PC correction. Exception and interrupt are also raised together, to tell a priority fault from a plain misroute. The block bit is tried with an ordinary code, with the escape code, and with an interrupt both awake and asleep, which separates a reset request, a normal entry and a masked event. Invalid vectors, idle cycles, a changed vector base and a mid-run reset check that state holds when nothing is taken and that the pulses last exactly one cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN       = 32;
    localparam int CODE_W     = 12;
    localparam int MASK_W     = 4;
    localparam int SR_MD      = 30;
    localparam int SR_RB      = 29;
    localparam int SR_BL      = 28;
    localparam int SR_FD      = 15;
    localparam int SR_MASK_LO = 4;
    localparam int PC_STEP    = 2;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic              taken;
        logic              rst_req;
        logic              wake;
        logic              dslot_clr;
    } entry_state_t;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
    import exc_entry_pkg::*;
#(
    parameter logic [CODE_W-1:0] ESCAPE_CODE = 12'h1E0
) (
    input  logic              exc_pend,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              irq_vec_ok,
    input  logic              blocked,
    input  logic              sleeping,
    output logic              take_exc,
    output logic              take_irq,
    output logic              reset_req
);
    logic escape;
    logic irq_open;

    always_comb begin
        escape    = (exc_code == ESCAPE_CODE);
        // exceptions win; a blocked exception turns into a reset request
        take_exc  = exc_pend && (!blocked || escape);
        reset_req = exc_pend && blocked && !escape;
        irq_open  = !blocked || sleeping;
        take_irq  = !exc_pend && irq_req && irq_open && irq_vec_ok;
    end
endmodule

// File: rtl/exc_entry_target.sv
module exc_entry_target
    import exc_entry_pkg::*;
#(
    parameter int                                   N_RST      = 3,
    parameter logic [N_RST-1:0][CODE_W-1:0]         RST_CODES  = {12'h140, 12'h020, 12'h000},
    parameter int                                   N_MISS     = 2,
    parameter logic [N_MISS-1:0][CODE_W-1:0]        MISS_CODES = {12'h060, 12'h040},
    parameter logic [CODE_W-1:0]                    TRAP_CODE  = 12'h160,
    parameter logic [XLEN-1:0]                      RESET_PC   = 32'hA000_0000,
    parameter logic [XLEN-1:0]                      OFS_GEN    = 32'h0000_0100,
    parameter logic [XLEN-1:0]                      OFS_MISS   = 32'h0000_0400,
    parameter logic [XLEN-1:0]                      OFS_IRQ    = 32'h0000_0600
) (
    input  logic [CODE_W-1:0] exc_code,
    input  logic              take_irq,
    input  logic [XLEN-1:0]   vbr,
    output logic [XLEN-1:0]   target_pc,
    output logic              rst_class,
    output logic              trap
);
    logic [N_RST-1:0]  rst_hit;
    logic [N_MISS-1:0] miss_hit;

    for (genvar i = 0; i < N_RST; i++) begin : g_rst
        assign rst_hit[i] = (exc_code == RST_CODES[i]);
    end

    for (genvar j = 0; j < N_MISS; j++) begin : g_miss
        assign miss_hit[j] = (exc_code == MISS_CODES[j]);
    end

    always_comb begin
        rst_class = !take_irq && (|rst_hit);
        trap      = !take_irq && (exc_code == TRAP_CODE);
        if (take_irq) begin
            target_pc = vbr + OFS_IRQ;
        end else if (|rst_hit) begin
            target_pc = RESET_PC;
        end else if (|miss_hit) begin
            target_pc = vbr + OFS_MISS;
        end else begin
            target_pc = vbr + OFS_GEN;
        end
    end
endmodule

// File: rtl/exc_entry_ctx.sv
module exc_entry_ctx
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic            dslot,
    input  logic            rst_class,
    input  logic            trap,
    output logic [XLEN-1:0] entry_sr,
    output logic [XLEN-1:0] save_pc
);
    always_comb begin
        entry_sr         = sr_in;
        entry_sr[SR_BL]  = 1'b1;
        entry_sr[SR_MD]  = 1'b1;
        entry_sr[SR_RB]  = 1'b1;
        if (rst_class) begin
            entry_sr[SR_FD]                  = 1'b0;
            entry_sr[SR_MASK_LO +: MASK_W]   = '1;
        end
        save_pc = pc_in;
        // step back so the branch owning the delay slot runs again
        if (dslot) save_pc = save_pc - XLEN'(PC_STEP);
        // a trap resumes after itself
        if (trap)  save_pc = save_pc + XLEN'(PC_STEP);
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [CODE_W-1:0] ESCAPE_CODE = 12'h1E0,
    parameter logic [XLEN-1:0]   RESET_PC    = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_pend,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              irq_vec_ok,
    input  logic [CODE_W-1:0] irq_vec,
    output logic [MASK_W-1:0] irq_lvl,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic              dslot_in,
    input  logic              sleep_in,
    output logic              taken,
    output logic              rst_req,
    output logic              wake,
    output logic              dslot_clr,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_sr,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   sgr,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt
);
    entry_state_t    st_d, st_q;
    logic            take_exc, take_irq, reset_hit;
    logic            rst_class, trap;
    logic [XLEN-1:0] target_pc, entry_sr, save_pc;

    exc_entry_arb #(.ESCAPE_CODE(ESCAPE_CODE)) i_arb (
        .exc_pend  (exc_pend),
        .exc_code  (exc_code),
        .irq_req   (irq_req),
        .irq_vec_ok(irq_vec_ok),
        .blocked   (sr_in[SR_BL]),
        .sleeping  (sleep_in),
        .take_exc  (take_exc),
        .take_irq  (take_irq),
        .reset_req (reset_hit)
    );

    exc_entry_target #(.RESET_PC(RESET_PC)) i_target (
        .exc_code (exc_code),
        .take_irq (take_irq),
        .vbr      (vbr_in),
        .target_pc(target_pc),
        .rst_class(rst_class),
        .trap     (trap)
    );

    exc_entry_ctx i_ctx (
        .sr_in    (sr_in),
        .pc_in    (pc_in),
        .dslot    (dslot_in),
        .rst_class(rst_class),
        .trap     (trap),
        .entry_sr (entry_sr),
        .save_pc  (save_pc)
    );

    always_comb begin
        st_d           = st_q;
        st_d.taken     = 1'b0;
        st_d.rst_req   = 1'b0;
        st_d.wake      = 1'b0;
        st_d.dslot_clr = 1'b0;
        if (take_exc || take_irq) begin
            st_d.taken     = 1'b1;
            st_d.wake      = 1'b1;
            st_d.dslot_clr = dslot_in;
            st_d.ssr       = sr_in;
            st_d.spc       = save_pc;
            st_d.sgr       = r15_in;
            st_d.sr        = entry_sr;
            st_d.pc        = target_pc;
            if (take_exc) st_d.expevt = exc_code;
            else          st_d.intevt = irq_vec;
        end else if (reset_hit) begin
            st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_lvl   = sr_in[SR_MASK_LO +: MASK_W];
    assign taken     = st_q.taken;
    assign rst_req   = st_q.rst_req;
    assign wake      = st_q.wake;
    assign dslot_clr = st_q.dslot_clr;
    assign new_pc    = st_q.pc;
    assign new_sr    = st_q.sr;
    assign ssr       = st_q.ssr;
    assign spc       = st_q.spc;
    assign sgr       = st_q.sgr;
    assign expevt    = st_q.expevt;
    assign intevt    = st_q.intevt;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              exc_pend,
    input logic [CODE_W-1:0] exc_code,
    input logic              irq_req,
    input logic              irq_vec_ok,
    input logic [CODE_W-1:0] irq_vec,
    input logic [XLEN-1:0]   sr_in,
    input logic [XLEN-1:0]   r15_in,
    input logic [XLEN-1:0]   vbr_in,
    input logic              sleep_in,
    input logic              taken,
    input logic              rst_req,
    input logic              dslot_clr,
    input logic [XLEN-1:0]   new_pc,
    input logic [XLEN-1:0]   new_sr,
    input logic [XLEN-1:0]   ssr,
    input logic [XLEN-1:0]   spc,
    input logic [XLEN-1:0]   sgr,
    input logic [CODE_W-1:0] expevt,
    input logic [CODE_W-1:0] intevt
);
    AST_EXC_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend && irq_req && irq_vec_ok && !sr_in[SR_BL]
        |=> taken && expevt == $past(exc_code) && intevt == $past(intevt)); // R1
    AST_BLOCKED_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend && sr_in[SR_BL] && exc_code != 12'h1E0
        |=> rst_req && !taken && $stable(new_pc) && $stable(spc)); // R2
    AST_ESCAPE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend && sr_in[SR_BL] && exc_code == 12'h1E0 |=> taken && !rst_req); // R3
    AST_BLOCKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_pend && sr_in[SR_BL] && !sleep_in |=> !taken); // R4
    AST_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_pend && !irq_vec_ok |=> !taken); // R5
    AST_SAVE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ssr == $past(sr_in) && sgr == $past(r15_in)
                  && new_sr[SR_BL] && new_sr[SR_MD] && new_sr[SR_RB]); // R6
    AST_DSLOT_WITH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        dslot_clr |-> taken); // R7
    AST_IRQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !$past(exc_pend)
        |-> new_pc == $past(vbr_in) + 32'h600 && intevt == $past(irq_vec)); // R11
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> !rst_req); // R12
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_pend && !irq_req
        |=> !taken && !rst_req && $stable(new_sr) && $stable(spc) && $stable(expevt)); // R12
endmodule

bind exc_entry_seq exc_entry_chk i_chk (.*);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
    import exc_entry_pkg::*;

    localparam logic [31:0] PC0  = 32'h0C00_1000;
    localparam logic [31:0] R15V = 32'h0C00_FFF0;
    localparam logic [31:0] VBR0 = 32'h8C00_0000;

    typedef struct packed {
        logic        exc;
        logic [11:0] code;
        logic        irq;
        logic        ok;
        logic [11:0] ivec;
        logic [31:0] sr;
        logic        ds;
        logic        slp;
        logic        e_tk;
        logic        e_rst;
        logic [31:0] e_pc;
        logic [31:0] e_sr;
        logic [31:0] e_spc;
        logic [11:0] e_exp;
        logic [11:0] e_int;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // general code -> base+0x100 (R9)
        '{1'b1,12'h0E0,1'b0,1'b0,12'h000,32'h0000_0030,1'b0,1'b0,1'b1,1'b0,32'h8C00_0100,32'h7000_0030,32'h0C00_1000,12'h0E0,12'h000},
        // exception and interrupt together (R1), miss code (R9)
        '{1'b1,12'h040,1'b1,1'b1,12'h200,32'h0000_0030,1'b0,1'b0,1'b1,1'b0,32'h8C00_0400,32'h7000_0030,32'h0C00_1000,12'h040,12'h000},
        '{1'b1,12'h060,1'b0,1'b0,12'h000,32'h0000_0030,1'b0,1'b0,1'b1,1'b0,32'h8C00_0400,32'h7000_0030,32'h0C00_1000,12'h060,12'h000},
        // trap (R10)
        '{1'b1,12'h160,1'b0,1'b0,12'h000,32'h0000_0030,1'b0,1'b0,1'b1,1'b0,32'h8C00_0100,32'h7000_0030,32'h0C00_1002,12'h160,12'h000},
        // trap in delay slot (R7, R10)
        '{1'b1,12'h160,1'b0,1'b0,12'h000,32'h0000_0030,1'b1,1'b0,1'b1,1'b0,32'h8C00_0100,32'h7000_0030,32'h0C00_1000,12'h160,12'h000},
        // reset class (R8)
        '{1'b1,12'h140,1'b0,1'b0,12'h000,32'h0000_8030,1'b0,1'b0,1'b1,1'b0,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,12'h140,12'h000},
        '{1'b1,12'h020,1'b0,1'b0,12'h000,32'h0000_8000,1'b1,1'b0,1'b1,1'b0,32'hA000_0000,32'h7000_00F0,32'h0C00_0FFE,12'h020,12'h000},
        // interrupt (R11)
        '{1'b0,12'h000,1'b1,1'b1,12'h3A0,32'h0000_0030,1'b0,1'b0,1'b1,1'b0,32'h8C00_0600,32'h7000_0030,32'h0C00_1000,12'h020,12'h3A0},
        // blocked exception -> reset request (R2)
        '{1'b1,12'h0E0,1'b1,1'b1,12'h3A0,32'h1000_0030,1'b0,1'b0,1'b0,1'b1,32'h8C00_0600,32'h7000_0030,32'h0C00_1000,12'h020,12'h3A0},
        // escape code while blocked (R3)
        '{1'b1,12'h1E0,1'b0,1'b0,12'h000,32'h1000_0030,1'b0,1'b0,1'b1,1'b0,32'h8C00_0100,32'h7000_0030,32'h0C00_1000,12'h1E0,12'h3A0},
        // blocked interrupt, awake then asleep (R4)
        '{1'b0,12'h000,1'b1,1'b1,12'h5C0,32'h1000_0030,1'b0,1'b0,1'b0,1'b0,32'h8C00_0100,32'h7000_0030,32'h0C00_1000,12'h1E0,12'h3A0},
        '{1'b0,12'h000,1'b1,1'b1,12'h5C0,32'h1000_0030,1'b0,1'b1,1'b1,1'b0,32'h8C00_0600,32'h7000_0030,32'h0C00_1000,12'h1E0,12'h5C0},
        // no valid vector (R5)
        '{1'b0,12'h000,1'b1,1'b0,12'h600,32'h0000_0030,1'b0,1'b0,1'b0,1'b0,32'h8C00_0600,32'h7000_0030,32'h0C00_1000,12'h1E0,12'h5C0},
        // idle (R12)
        '{1'b0,12'h000,1'b0,1'b0,12'h000,32'h0000_0030,1'b0,1'b0,1'b0,1'b0,32'h8C00_0600,32'h7000_0030,32'h0C00_1000,12'h1E0,12'h5C0},
        // reset-class code zero (R8)
        '{1'b1,12'h000,1'b0,1'b0,12'h000,32'h0000_00A0,1'b0,1'b0,1'b1,1'b0,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,12'h000,12'h5C0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_pend = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic        irq_vec_ok = 1'b0;
    logic [11:0] irq_vec = '0;
    logic [3:0]  irq_lvl;
    logic [31:0] sr_in = '0;
    logic [31:0] pc_in = PC0;
    logic [31:0] r15_in = R15V;
    logic [31:0] vbr_in = VBR0;
    logic        dslot_in = 1'b0;
    logic        sleep_in = 1'b0;
    logic        taken, rst_req, wake, dslot_clr;
    logic [31:0] new_pc, new_sr, ssr, spc, sgr;
    logic [11:0] expevt, intevt;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_ssr = '0;
    logic [31:0] exp_sgr = '0;

    always #2.5 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic idle_inputs();
        exc_pend = 1'b0; irq_req = 1'b0; irq_vec_ok = 1'b0;
        dslot_in = 1'b0; sleep_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R12)
        chk("R12 reset taken", {31'b0, taken}, 32'h0);
        chk("R12 reset new_pc", new_pc, 32'h0);
        chk("R12 reset expevt", {20'b0, expevt}, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            exc_pend = VECS[k].exc; exc_code = VECS[k].code;
            irq_req = VECS[k].irq; irq_vec_ok = VECS[k].ok; irq_vec = VECS[k].ivec;
            sr_in = VECS[k].sr; dslot_in = VECS[k].ds; sleep_in = VECS[k].slp;
            if (VECS[k].e_tk) begin exp_ssr = VECS[k].sr; exp_sgr = R15V; end
            @(negedge clk);
            chk($sformatf("R12 taken v%0d", k), {31'b0, taken}, {31'b0, VECS[k].e_tk});
            chk($sformatf("R2 rst_req v%0d", k), {31'b0, rst_req}, {31'b0, VECS[k].e_rst});
            chk($sformatf("R9 new_pc v%0d", k), new_pc, VECS[k].e_pc);
            chk($sformatf("R6 new_sr v%0d", k), new_sr, VECS[k].e_sr);
            chk($sformatf("R7 spc v%0d", k), spc, VECS[k].e_spc);
            chk($sformatf("R11 expevt v%0d", k), {20'b0, expevt}, {20'b0, VECS[k].e_exp});
            chk($sformatf("R11 intevt v%0d", k), {20'b0, intevt}, {20'b0, VECS[k].e_int});
            chk($sformatf("R6 ssr v%0d", k), ssr, exp_ssr);
            chk($sformatf("R6 sgr v%0d", k), sgr, exp_sgr);
            chk($sformatf("R4 wake v%0d", k), {31'b0, wake}, {31'b0, VECS[k].e_tk});
            chk($sformatf("R7 dslot_clr v%0d", k), {31'b0, dslot_clr},
                {31'b0, VECS[k].e_tk & VECS[k].ds});
        end

        // mask level output follows status bits 7:4 (R5)
        idle_inputs();
        sr_in = 32'h0000_00A0;
        #1;
        chk("R5 irq_lvl", {28'b0, irq_lvl}, 32'h0000_000A);

        // different vector base with a miss code (R9)
        @(negedge clk);
        vbr_in = 32'h0000_1000; sr_in = 32'h0000_0030;
        exc_pend = 1'b1; exc_code = 12'h040;
        @(negedge clk);
        chk("R9 miss base", new_pc, 32'h0000_1400);
        chk("R12 taken pulse high", {31'b0, taken}, 32'h1);
        idle_inputs();
        @(negedge clk);
        chk("R12 taken pulse low", {31'b0, taken}, 32'h0);
        chk("R12 hold pc", new_pc, 32'h0000_1400);

        // mid-run reset clears state (R12)
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset clears pc", new_pc, 32'h0);
        chk("R12 reset clears intevt", {20'b0, intevt}, 32'h0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule